// File: doc/BRIEF.md
# Octant-Based Two-Coil Angle Decoder

This block turns a 10-bit pointer angle into two signed drive codes, one for the sine coil and one for the cosine coil of a two-coil pointer movement. The full circle is split into 1024 steps of about 0.35 degrees each. The three most significant bits of the code pick one of eight 45-degree octants. The seven low bits pick one of 128 positions inside that octant.

The decoder does not evaluate true sine and cosine. In every octant one coil is driven at full-scale magnitude with a fixed sign. The other coil follows a 128-entry ramp table. The table index runs forward in even octants and backward in odd octants, so the drive stays continuous where two octants meet. Both coils therefore reach full magnitude together near the odd 45-degree points.

A new code is taken when the strobe is high. The drive pair appears on the next clock and stays there until the next strobe.

Top module: `two_coil_angle_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sin_code` and `cos_code` are 0 and `out_valid` is 0.
- R2: A code presented with `in_valid` high at a rising edge appears on `sin_code`/`cos_code` immediately after that edge. `out_valid` rises at the same time and then stays high until reset.
- R3: When `in_valid` is low, changes on `angle_code` have no effect. Both outputs keep their last values.
- R4: `angle_code[9:7]` is the octant number o (0 to 7) and `angle_code[6:0]` is the step s (0 to 127).
- R5: The saturating coil per octant is: o=0 and o=7 give cos=+FS; o=1 and o=2 give sin=+FS; o=3 and o=4 give cos=-FS; o=5 and o=6 give sin=-FS. FS is `FULL_SCALE`, default 511.
- R6: The ramping coil per octant is: o=0 gives sin=+T; o=1 gives cos=+T; o=2 gives cos=-T; o=3 gives sin=+T; o=4 gives sin=-T; o=5 gives cos=-T; o=6 gives cos=+T; o=7 gives sin=-T. T is table[s] in even octants and table[127-s] in odd octants.
- R7: With the default `RAMP_MODE`=0, table[i] = floor(i*FS/128). With `RAMP_MODE`=1, table[i] = floor(FS*i*(256-i)/16384).
- R8: Both outputs are 10-bit two's complement codes. Their magnitude never exceeds FS.
- R9: Once `out_valid` is high, at least one output has magnitude exactly FS.
- R10: The reference codes decode as follows, with the default parameters: 0 gives (sin,cos)=(0,511); 128 gives (511,507); 256 gives (511,0); 384 gives (507,-511); 512 gives (0,-511); 640 gives (-511,-507); 768 gives (-511,0); 896 gives (-507,511); 1023 gives (0,511).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe; `angle_code` is taken when high |
| angle_code | input | 10 | Octant in bits 9:7, step in bits 6:0 |
| sin_code | output | 10 | Signed sine-coil drive code |
| cos_code | output | 10 | Signed cosine-coil drive code |
| out_valid | output | 1 | High once a code has been decoded since reset |

## Verification
The following are checked by assertions on every cycle:
- both outputs stay within ±FS;
- one coil sits at full scale whenever the outputs are valid;
- the outputs hold still without a strobe;
- `out_valid` is sticky;
- the sign of each coil matches the octant of the previous strobe.

Other behaviour is shown only by the bench's scenarios. This covers the exact ramp values, the reversed index in odd octants, and the nine reference codes. It also covers the one-cycle latency of back-to-back strobes and the reset values. The bench applies all 1024 codes and compares each result with a model written from the requirements.

// File: rtl/coil_angle_pkg.sv
package coil_angle_pkg;

  // Per-octant drive plan
  typedef struct packed {
    logic sat_on_sin;   // 1: sine coil saturates, cosine ramps
    logic sat_neg;      // saturating coil is negative
    logic ramp_neg;     // ramping coil is negative
    logic rev_index;    // ramp table read backwards
  } octant_plan_t;

  localparam int unsigned OCT_BITS = 3;

endpackage

// File: rtl/octant_planner.sv
module octant_planner
  import coil_angle_pkg::*;
(
  input  logic [OCT_BITS-1:0] octant,
  output octant_plan_t        plan
);

  always_comb begin
    plan.rev_index = octant[0];
    unique case (octant)
      3'd0: begin plan.sat_on_sin = 1'b0; plan.sat_neg = 1'b0; plan.ramp_neg = 1'b0; end
      3'd1: begin plan.sat_on_sin = 1'b1; plan.sat_neg = 1'b0; plan.ramp_neg = 1'b0; end
      3'd2: begin plan.sat_on_sin = 1'b1; plan.sat_neg = 1'b0; plan.ramp_neg = 1'b1; end
      3'd3: begin plan.sat_on_sin = 1'b0; plan.sat_neg = 1'b1; plan.ramp_neg = 1'b0; end
      3'd4: begin plan.sat_on_sin = 1'b0; plan.sat_neg = 1'b1; plan.ramp_neg = 1'b1; end
      3'd5: begin plan.sat_on_sin = 1'b1; plan.sat_neg = 1'b1; plan.ramp_neg = 1'b1; end
      3'd6: begin plan.sat_on_sin = 1'b1; plan.sat_neg = 1'b1; plan.ramp_neg = 1'b0; end
      default: begin plan.sat_on_sin = 1'b0; plan.sat_neg = 1'b0; plan.ramp_neg = 1'b1; end
    endcase
  end

endmodule

// File: rtl/angle_ramp_rom.sv
module angle_ramp_rom #(
  parameter int unsigned STEP_W     = 7,
  parameter int unsigned MAG_W      = 9,
  parameter int unsigned FULL_SCALE = 511,
  parameter int unsigned RAMP_MODE  = 0
) (
  input  logic [STEP_W-1:0] step,
  input  logic              reverse,
  output logic [MAG_W-1:0]  mag
);

  localparam int unsigned DEPTH = 1 << STEP_W;

  function automatic logic [MAG_W-1:0] ramp_entry(input int unsigned idx);
    longint unsigned v;
    if (RAMP_MODE == 1)
      v = (longint'(FULL_SCALE) * idx * (2 * DEPTH - idx)) / (longint'(DEPTH) * DEPTH);
    else
      v = (longint'(FULL_SCALE) * idx) / DEPTH;
    return MAG_W'(v);
  endfunction

  logic [MAG_W-1:0]  table_q [DEPTH];
  logic [STEP_W-1:0] addr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_q[i] = ramp_entry(i);
  end

  // Odd octants read backwards: DEPTH-1-step equals the bitwise inverse
  assign addr = reverse ? ~step : step;
  assign mag  = table_q[addr];

endmodule

// File: rtl/coil_composer.sv
module coil_composer
  import coil_angle_pkg::*;
#(
  parameter int unsigned OUT_W      = 10,
  parameter int unsigned FULL_SCALE = 511
) (
  input  octant_plan_t             plan,
  input  logic [OUT_W-2:0]         ramp_mag,
  output logic signed [OUT_W-1:0]  sin_next,
  output logic signed [OUT_W-1:0]  cos_next
);

  localparam logic signed [OUT_W-1:0] FS_POS = OUT_W'(FULL_SCALE);

  logic signed [OUT_W-1:0] sat_val;
  logic signed [OUT_W-1:0] ramp_pos;
  logic signed [OUT_W-1:0] ramp_val;

  assign sat_val  = plan.sat_neg ? -FS_POS : FS_POS;
  assign ramp_pos = $signed({1'b0, ramp_mag});
  assign ramp_val = plan.ramp_neg ? -ramp_pos : ramp_pos;

  always_comb begin
    if (plan.sat_on_sin) begin
      sin_next = sat_val;
      cos_next = ramp_val;
    end else begin
      sin_next = ramp_val;
      cos_next = sat_val;
    end
  end

endmodule

// File: rtl/two_coil_angle_decoder.sv
module two_coil_angle_decoder
  import coil_angle_pkg::*;
#(
  parameter int unsigned ANGLE_W    = 10,
  parameter int unsigned OUT_W      = 10,
  parameter int unsigned FULL_SCALE = 511,
  parameter int unsigned RAMP_MODE  = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [ANGLE_W-1:0]       angle_code,
  output logic signed [OUT_W-1:0]  sin_code,
  output logic signed [OUT_W-1:0]  cos_code,
  output logic                     out_valid
);

  localparam int unsigned STEP_W = ANGLE_W - OCT_BITS;
  localparam int unsigned MAG_W  = OUT_W - 1;

  initial begin
    if (FULL_SCALE >= (1 << MAG_W))
      $error("FULL_SCALE does not fit the signed output width");
  end

  octant_plan_t            plan;
  logic [MAG_W-1:0]        ramp_mag;
  logic signed [OUT_W-1:0] sin_next;
  logic signed [OUT_W-1:0] cos_next;

  octant_planner u_plan (
    .octant (angle_code[ANGLE_W-1 -: OCT_BITS]),
    .plan   (plan)
  );

  angle_ramp_rom #(
    .STEP_W     (STEP_W),
    .MAG_W      (MAG_W),
    .FULL_SCALE (FULL_SCALE),
    .RAMP_MODE  (RAMP_MODE)
  ) u_rom (
    .step    (angle_code[STEP_W-1:0]),
    .reverse (plan.rev_index),
    .mag     (ramp_mag)
  );

  coil_composer #(
    .OUT_W      (OUT_W),
    .FULL_SCALE (FULL_SCALE)
  ) u_comp (
    .plan     (plan),
    .ramp_mag (ramp_mag),
    .sin_next (sin_next),
    .cos_next (cos_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_code  <= '0;
      cos_code  <= '0;
      out_valid <= 1'b0;
    end else if (in_valid) begin
      sin_code  <= sin_next;
      cos_code  <= cos_next;
      out_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/two_coil_angle_decoder_chk.sv
module two_coil_angle_decoder_chk #(
  parameter int unsigned OUT_W      = 10,
  parameter int unsigned FULL_SCALE = 511
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [2:0]              oct_in,
  input logic signed [OUT_W-1:0] sin_code,
  input logic signed [OUT_W-1:0] cos_code,
  input logic                    out_valid
);

  localparam logic signed [OUT_W-1:0] FS = OUT_W'(FULL_SCALE);

  // R8: magnitude bound
  p_mag_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (sin_code <= FS) && (sin_code >= -FS) && (cos_code <= FS) && (cos_code >= -FS));

  // R9: one coil always saturated
  p_one_saturated_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sin_code == FS || sin_code == -FS || cos_code == FS || cos_code == -FS));

  // R3: hold without strobe
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sin_code) && $stable(cos_code)));

  // R2: valid rises after strobe and is sticky
  p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R5, R6: sign of each coil follows the octant
  p_sin_sign_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ($past(oct_in[2]) ? (sin_code <= 0) : (sin_code >= 0)));
  p_cos_sign_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (($past(oct_in[2]) ^ $past(oct_in[1])) ? (cos_code <= 0) : (cos_code >= 0)));

endmodule

bind two_coil_angle_decoder two_coil_angle_decoder_chk #(
  .OUT_W      (OUT_W),
  .FULL_SCALE (FULL_SCALE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .oct_in    (angle_code[ANGLE_W-1 -: 3]),
  .sin_code  (sin_code),
  .cos_code  (cos_code),
  .out_valid (out_valid)
);

// File: tb/two_coil_angle_decoder_bench.sv
module two_coil_angle_decoder_bench;

  localparam int FS = 511;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [9:0] angle_code = '0;
  logic signed [9:0] sin_code, cos_code;
  logic out_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  two_coil_angle_decoder u_two_coil_angle_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .angle_code(angle_code),
    .sin_code(sin_code), .cos_code(cos_code), .out_valid(out_valid)
  );

  // Model built from R4..R7
  function automatic void model(input int code, output int s, output int c);
    int o, st, t;
    o  = code >> 7;
    st = code & 127;
    t  = ((o % 2) ? (127 - st) : st) * FS / 128;
    case (o)
      0: begin c =  FS; s =  t; end
      1: begin s =  FS; c =  t; end
      2: begin s =  FS; c = -t; end
      3: begin c = -FS; s =  t; end
      4: begin c = -FS; s = -t; end
      5: begin s = -FS; c = -t; end
      6: begin s = -FS; c =  t; end
      default: begin c = FS; s = -t; end
    endcase
  endfunction

  task automatic check(input string req, input int s_exp, input int c_exp, input bit v_exp);
    n_checks++;
    if (int'(sin_code) != s_exp || int'(cos_code) != c_exp || out_valid != v_exp) begin
      n_fail++;
      $display("FAIL %s: got sin=%0d cos=%0d valid=%0b, expected sin=%0d cos=%0d valid=%0b",
               req, sin_code, cos_code, out_valid, s_exp, c_exp, v_exp);
    end
  endtask

  // One strobe; outputs are sampled on the falling edge after the capturing rise
  task automatic apply(input int code);
    @(negedge clk);
    angle_code = 10'(code);
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid   = 1'b0;
  endtask

  task automatic t_reset;   // R1
    @(negedge clk);
    check("R1 during reset", 0, 0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 0, 0, 1'b0);
  endtask

  task automatic t_reference;   // R10, R5
    int codes [9] = '{0, 128, 256, 384, 512, 640, 768, 896, 1023};
    int s_ref [9] = '{0, 511, 511, 507, 0, -511, -511, -507, 0};
    int c_ref [9] = '{511, 507, 0, -511, -511, -507, 0, 511, 511};
    for (int i = 0; i < 9; i++) begin
      apply(codes[i]);
      check($sformatf("R10 R5 code %0d", codes[i]), s_ref[i], c_ref[i], 1'b1);
    end
  endtask

  task automatic t_hold;   // R3, R2 sticky valid
    int s, c;
    apply(300);
    model(300, s, c);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      angle_code = 10'(700 + k);
    end
    @(negedge clk);
    check("R3 hold without strobe", s, c, 1'b1);
  endtask

  task automatic t_back_to_back;   // R2 latency
    int s, c;
    @(negedge clk);
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      angle_code = 10'(127 + k * 129);
      @(negedge clk);
      model(127 + k * 129, s, c);
      check("R2 one-cycle latency", s, c, 1'b1);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_sweep;   // R4 R6 R7 R8 R9
    int s, c;
    for (int code = 0; code < 1024; code++) begin
      apply(code);
      model(code, s, c);
      check("R4 R6 R7 sweep", s, c, 1'b1);
    end
  endtask

  task automatic t_boundary;   // R6 continuity at octant edges
    int s, c;
    for (int o = 1; o < 8; o++) begin
      apply(o * 128 - 1);
      model(o * 128 - 1, s, c);
      check("R6 octant end", s, c, 1'b1);
    end
  endtask

  task automatic t_re_reset;   // R1 again mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", 0, 0, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_reference();
    t_hold();
    t_back_to_back();
    t_boundary();
    t_sweep();
    t_re_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule